// File: doc/BRIEF.md
# ATM Transmit Cell Buffer with Programmable Cell-Available

This block is the transmit side of a PHY-layer cell interface. An ATM layer device pushes cells into it one beat at a time: a data bus that is either 8 or 16 bits wide, a start-of-cell marker, an enable and a parity bit. The block keeps up to four complete cells in a ring of cell slots. It tells the sender through a cell-available output whether more cells may be sent, using a free-space threshold that software can change. Logic on the line side drains whole cells through a simple word-read port.

A 7-bit control register sets the bus width, the parity sense, the handshake granularity, the Level 1 or Level 2 mode flag and the threshold. Writing a one to its clear bit empties the buffer at once and drops any cell that is only partly written. Each beat is parity-checked, and any failure sets a sticky flag. A start-of-cell that arrives in the middle of a cell restarts the cell, so the write position always lines up with the sender's cell boundary.

Top module: `utx_cell_fifo`

## Requirements
- R1: After reset the control register holds 8-bit bus, cell handshake, odd parity, threshold code 00 and Level 1. With the buffer empty, tx_clav=1, cell_ready=0, par_err=0 and mode_l2=0.
- R2: In 8-bit mode (cfg bit0=1) a cell is 53 beats with tx_en=1, the first of them carrying tx_soc=1. Only tx_data[7:0] is kept, and it reads back with bits 15:8 at zero. cell_ready stays 0 until the 53rd beat has been taken.
- R3: In 16-bit mode (cfg bit0=0) a cell is 27 beats, and all 16 bits of each beat are stored and read back unchanged.
- R4: Free space is 4 minus the stored cells minus one slot for a cell that is partly written. In octet mode tx_clav=1 exactly when free space is at least the need of threshold code cfg[5:4]: 00 needs 1, 01 needs 2, 10 and 11 need 3.
- R5: With cfg bit2=1 (cell handshake), tx_clav is evaluated only while no cell is open and holds that value for the whole cell. With cfg bit2=0 (octet handshake) it is re-evaluated every cycle.
- R6: Parity covers tx_data[7:0] in 8-bit mode and tx_data[15:0] in 16-bit mode, plus tx_par. With cfg bit1=1 the total count of ones must be even, and with bit1=0 it must be odd. A failing beat sets par_err, which stays set until a pointer clear. The beat's data is still stored.
- R7: A start-of-cell that arrives in the middle of a cell throws away the partial cell and starts a new one in the same slot. A beat without tx_soc while no cell is open is ignored.
- R8: A cell whose start-of-cell arrives while four cells are stored is thrown away entirely. The stored cells are not changed.
- R9: A control write with bit6=1 empties the buffer, drops any open cell and clears par_err, all on the same edge. The other fields are written from the same data.
- R10: Cells leave in the order they arrived. rd_data shows the current word, rd_sop=1 on the first word of a cell, and each cycle with rd_en=1 and cell_ready=1 moves to the next word.
- R11: mode_l2 follows cfg bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control data: [0] 8-bit bus, [1] even parity, [2] cell handshake, [3] Level 2, [5:4] threshold, [6] pointer clear |
| tx_data | input | 16 | Transmit data beat |
| tx_soc | input | 1 | Start of cell, on the first beat |
| tx_en | input | 1 | Beat valid |
| tx_par | input | 1 | Parity bit of the beat |
| tx_clav | output | 1 | Cell available to the sender |
| rd_en | input | 1 | Line-side read advance |
| cell_ready | output | 1 | At least one complete cell is stored |
| rd_data | output | 16 | Current word of the oldest cell |
| rd_sop | output | 1 | Current word is the first word of a cell |
| par_err | output | 1 | Sticky parity error flag |
| mode_l2 | output | 1 | Level 2 mode select |

## Verification
The hardest state to reach is a cell that is partly written while the other three slots hold complete cells. Only in that state do the held and the live cell-available values differ. The bench loads three cells, opens a fourth and stops in the middle of it, then samples tx_clav once in cell handshake and once in octet handshake. The same partial-cell state is used to show that a pointer clear drops the truncated cell cleanly and that a mid-cell start-of-cell replaces it.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int IDX_W = 6;

  typedef struct packed {
    logic [1:0] thresh;
    logic       level2;
    logic       cell_hs;
    logic       even_par;
    logic       bus8;
  } utx_cfg_t;

  localparam utx_cfg_t CFG_RESET = '{thresh: 2'b00, level2: 1'b0, cell_hs: 1'b1,
                                     even_par: 1'b0, bus8: 1'b1};

  function automatic logic [IDX_W-1:0] beats_per_cell(input logic bus8);
    return bus8 ? IDX_W'(53) : IDX_W'(27);
  endfunction

  function automatic logic [2:0] cells_needed(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd3;
    endcase
  endfunction

  function automatic logic parity_ok(input logic [15:0] d, input logic bus8,
                                     input logic even, input logic p);
    logic ones;
    ones = (bus8 ? (^d[7:0]) : (^d)) ^ p;
    return even ? (ones == 1'b0) : (ones == 1'b1);
  endfunction
endpackage

// File: rtl/utx_cfg_reg.sv
module utx_cfg_reg
  import utx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [6:0] wdata,
  output utx_cfg_t   cfg,
  output logic       ptr_clr
);
  assign ptr_clr = we & wdata[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= CFG_RESET;
    else if (we) cfg <= utx_cfg_t'(wdata[5:0]);
  end

  // R1
  cfg_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> cfg == CFG_RESET);
endmodule

// File: rtl/utx_parity_chk.sv
module utx_parity_chk
  import utx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        beat,
  input  logic [15:0] data,
  input  logic        par,
  input  logic        bus8,
  input  logic        even,
  input  logic        clr,
  output logic        par_err
);
  logic bad_beat;
  assign bad_beat = beat && !parity_ok(data, bus8, even, par);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        par_err <= 1'b0;
    else if (clr)      par_err <= 1'b0;
    else if (bad_beat) par_err <= 1'b1;
  end

  // R6
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && !clr) |=> par_err);
endmodule

// File: rtl/utx_cell_buf.sv
module utx_cell_buf
  import utx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CELLS  = 4,
  localparam int SLOT_W = $clog2(CELLS),
  localparam int PTR_W  = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              soc,
  input  logic [DATA_W-1:0] data,
  input  logic              bus8,
  input  logic              clr,
  input  logic              rd_en,
  output logic              cell_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic [PTR_W-1:0]  used,
  output logic              in_cell
);
  logic [DATA_W-1:0] mem [CELLS*(1<<IDX_W)];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [IDX_W-1:0]  wr_cnt, rd_cnt, last_idx, wr_idx;
  logic              has_room, start_ok, take, commit, pop;
  logic [DATA_W-1:0] wr_word;

  assign last_idx = beats_per_cell(bus8) - IDX_W'(1);
  assign used     = wr_ptr - rd_ptr;
  assign in_cell  = (wr_cnt != '0);
  assign has_room = (used < PTR_W'(CELLS));
  assign start_ok = soc && (in_cell || has_room);
  assign take     = beat && (start_ok || (!soc && in_cell));
  assign wr_idx   = soc ? '0 : wr_cnt;
  assign commit   = take && (wr_idx == last_idx);
  assign wr_word  = bus8 ? {{(DATA_W-8){1'b0}}, data[7:0]} : data;

  always_ff @(posedge clk) begin
    if (take && !clr) mem[{wr_ptr[SLOT_W-1:0], wr_idx}] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      wr_cnt <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      wr_cnt <= '0;
    end else if (take) begin
      wr_cnt <= commit ? '0 : wr_idx + IDX_W'(1);
      if (commit) wr_ptr <= wr_ptr + PTR_W'(1);
    end
  end

  assign cell_ready = (used != '0);
  assign rd_data    = mem[{rd_ptr[SLOT_W-1:0], rd_cnt}];
  assign rd_sop     = cell_ready && (rd_cnt == '0);
  assign pop        = rd_en && cell_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      rd_cnt <= '0;
    end else if (clr) begin
      rd_ptr <= '0;
      rd_cnt <= '0;
    end else if (pop) begin
      if (rd_cnt == last_idx) begin
        rd_cnt <= '0;
        rd_ptr <= rd_ptr + PTR_W'(1);
      end else begin
        rd_cnt <= rd_cnt + IDX_W'(1);
      end
    end
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PTR_W'(CELLS));
  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!cell_ready && !in_cell));
  // R2
  ready_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cell_ready) |-> $past(beat));
endmodule

// File: rtl/utx_cell_fifo.sv
module utx_cell_fifo
  import utx_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CELLS  = 4,
  localparam int PTR_W = $clog2(CELLS) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_wdata,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_soc,
  input  logic              tx_en,
  input  logic              tx_par,
  output logic              tx_clav,
  input  logic              rd_en,
  output logic              cell_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_sop,
  output logic              par_err,
  output logic              mode_l2
);
  utx_cfg_t         cfg;
  logic             ptr_clr, in_cell, clav_raw, clav_hold;
  logic [PTR_W-1:0] used, free_cells;

  utx_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .ptr_clr(ptr_clr)
  );

  utx_parity_chk u_par (
    .clk(clk), .rst_n(rst_n), .beat(tx_en), .data(tx_data), .par(tx_par),
    .bus8(cfg.bus8), .even(cfg.even_par), .clr(ptr_clr), .par_err(par_err)
  );

  utx_cell_buf #(.DATA_W(DATA_W), .CELLS(CELLS)) u_buf (
    .clk(clk), .rst_n(rst_n), .beat(tx_en), .soc(tx_soc), .data(tx_data),
    .bus8(cfg.bus8), .clr(ptr_clr), .rd_en(rd_en), .cell_ready(cell_ready),
    .rd_data(rd_data), .rd_sop(rd_sop), .used(used), .in_cell(in_cell)
  );

  assign free_cells = PTR_W'(CELLS) - used - PTR_W'(in_cell);
  assign clav_raw   = (free_cells >= PTR_W'(cells_needed(cfg.thresh)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        clav_hold <= 1'b1;
    else if (!in_cell) clav_hold <= clav_raw;
  end

  assign tx_clav = (cfg.cell_hs && in_cell) ? clav_hold : clav_raw;
  assign mode_l2 = cfg.level2;

  // R4
  clav_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.cell_hs && used == PTR_W'(CELLS)) |-> !tx_clav);
  // R5
  clav_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.cell_hs && in_cell && $past(in_cell) && $stable(cfg)) |-> $stable(tx_clav));
endmodule

// File: tb/tb_utx_cell_fifo.sv
module tb_utx_cell_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic [15:0] tx_data = '0;
  logic        tx_soc = 1'b0, tx_en = 1'b0, tx_par = 1'b0, rd_en = 1'b0;
  logic        tx_clav, cell_ready, rd_sop, par_err, mode_l2;
  logic [15:0] rd_data;

  int vectors = 0, errors = 0;
  bit cur_bus8 = 1'b1, cur_even = 1'b0;

  always #10 clk = ~clk;

  utx_cell_fifo dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .tx_data(tx_data), .tx_soc(tx_soc), .tx_en(tx_en), .tx_par(tx_par),
    .tx_clav(tx_clav), .rd_en(rd_en), .cell_ready(cell_ready),
    .rd_data(rd_data), .rd_sop(rd_sop), .par_err(par_err), .mode_l2(mode_l2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] wd(input int seed, input int i);
    return 16'((seed << 8) ^ (i * 37 + 1) ^ (seed * 4099));
  endfunction

  function automatic logic [15:0] stored(input logic [15:0] d, input bit bus8);
    return bus8 ? {8'h00, d[7:0]} : d;
  endfunction

  task automatic set_cfg(input bit bus8, input bit even, input bit chs, input bit l2,
                         input logic [1:0] thr, input bit clr);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {clr, thr, l2, chs, even, bus8};
    @(negedge clk);
    cfg_we = 1'b0;
    cur_bus8 = bus8;
    cur_even = even;
  endtask

  task automatic beat(input logic [15:0] d, input bit soc, input bit bad);
    logic ones;
    @(negedge clk);
    ones = cur_bus8 ? (^d[7:0]) : (^d);
    tx_en = 1'b1;
    tx_soc = soc;
    tx_data = d;
    tx_par = (cur_even ? ones : ~ones) ^ bad;
  endtask

  task automatic idle();
    @(negedge clk);
    tx_en = 1'b0;
    tx_soc = 1'b0;
  endtask

  function automatic int cell_len();
    return cur_bus8 ? 53 : 27;
  endfunction

  task automatic send_cell(input int seed, input int bad_idx);
    for (int i = 0; i < cell_len(); i++) beat(wd(seed, i), i == 0, i == bad_idx);
    idle();
  endtask

  task automatic read_cell(input string req, input int seed);
    int n;
    n = cell_len();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_en = 1'b1;
      #1;
      if (i == 0) chk({req, " sop"}, 32'(rd_sop), 32'd1);
      if (i == 1) chk({req, " sop mid"}, 32'(rd_sop), 32'd0);
      if (rd_data !== stored(wd(seed, i), cur_bus8)) chk({req, " data"}, 32'(rd_data), 32'(stored(wd(seed, i), cur_bus8)));
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 clav", 32'(tx_clav), 32'd1);
    chk("R1 cell_ready", 32'(cell_ready), 32'd0);
    chk("R1 par_err", 32'(par_err), 32'd0);
    chk("R1 mode_l2", 32'(mode_l2), 32'd0);
    send_cell(3, -1);
    chk("R1 8-bit default gives 53-beat cell", 32'(cell_ready), 32'd1);
    read_cell("R1", 3);
    chk("R1 odd parity default", 32'(par_err), 32'd0);
  endtask

  task automatic t_byte_cell();
    for (int i = 0; i < 52; i++) beat(16'hA500 | wd(11, i), i == 0, 1'b0);
    idle();
    chk("R2 not ready before last beat", 32'(cell_ready), 32'd0);
    beat(wd(11, 52), 1'b0, 1'b0);
    idle();
    chk("R2 ready after last beat", 32'(cell_ready), 32'd1);
    read_cell("R2 R10", 11);
    chk("R10 drained", 32'(cell_ready), 32'd0);
  endtask

  task automatic t_word_cell();
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
    send_cell(21, -1);
    send_cell(22, -1);
    read_cell("R3 R10 first", 21);
    read_cell("R3 R10 second", 22);
    chk("R3 drained", 32'(cell_ready), 32'd0);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
  endtask

  task automatic t_threshold();
    for (int code = 0; code < 4; code++) begin
      int need;
      need = (code == 0) ? 1 : (code == 1) ? 2 : 3;
      set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'(code), 1'b1);
      for (int k = 0; k <= 4; k++) begin
        chk($sformatf("R4 code %0d stored %0d", code, k), 32'(tx_clav), 32'((4 - k) >= need));
        if (k < 4) send_cell(30 + k, -1);
      end
    end
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic t_hold();
    for (int m = 0; m < 2; m++) begin
      set_cfg(1'b1, 1'b0, m == 0, 1'b0, 2'b00, 1'b1);
      for (int k = 0; k < 3; k++) send_cell(40 + k, -1);
      chk("R5 boundary clav", 32'(tx_clav), 32'd1);
      for (int i = 0; i < 10; i++) beat(wd(43, i), i == 0, 1'b0);
      idle();
      if (m == 0) chk("R5 cell mode holds clav mid-cell", 32'(tx_clav), 32'd1);
      else        chk("R5 octet mode drops clav mid-cell", 32'(tx_clav), 32'd0);
      for (int i = 10; i < 53; i++) beat(wd(43, i), 1'b0, 1'b0);
      idle();
      chk("R5 full after fourth cell", 32'(tx_clav), 32'd0);
    end
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic t_full();
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
    for (int k = 0; k < 4; k++) send_cell(50 + k, -1);
    send_cell(59, -1);
    for (int k = 0; k < 4; k++) read_cell("R8 R10 order", 50 + k);
    chk("R8 fifth cell dropped", 32'(cell_ready), 32'd0);
  endtask

  task automatic t_parity();
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1);
    send_cell(61, -1);
    chk("R6 odd good", 32'(par_err), 32'd0);
    send_cell(62, 5);
    chk("R6 odd bad sets flag", 32'(par_err), 32'd1);
    send_cell(63, -1);
    chk("R6 sticky", 32'(par_err), 32'd1);
    read_cell("R6 data kept", 61);
    read_cell("R6 data kept bad cell", 62);
    read_cell("R6 data kept after", 63);
    set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1);
    chk("R9 clear drops par_err", 32'(par_err), 32'd0);
    send_cell(64, -1);
    chk("R6 even 16-bit good", 32'(par_err), 32'd0);
    beat(16'h0001, 1'b1, 1'b0);
    beat(16'h0100, 1'b0, 1'b0);
    idle();
    chk("R6 upper byte counted in 16-bit mode", 32'(par_err), 32'd0);
    beat(16'h8000, 1'b0, 1'b1);
    idle();
    chk("R6 even bad sets flag", 32'(par_err), 32'd1);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1);
  endtask

  task automatic t_soc_mid();
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 1'b1);
    send_cell(70, -1);
    chk("R7 one cell stored clav", 32'(tx_clav), 32'd1);
    for (int i = 0; i < 3; i++) beat(16'h00F0 + 16'(i), 1'b0, 1'b0);
    idle();
    chk("R7 stray beats ignored", 32'(tx_clav), 32'd1);
    for (int i = 0; i < 10; i++) beat(wd(71, i), i == 0, 1'b0);
    idle();
    chk("R7 partial cell open", 32'(tx_clav), 32'd0);
    send_cell(72, -1);
    read_cell("R7 first", 70);
    read_cell("R7 restarted cell", 72);
    chk("R7 partial discarded", 32'(cell_ready), 32'd0);
  endtask

  task automatic t_clear();
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1);
    send_cell(80, 2);
    for (int i = 0; i < 20; i++) beat(wd(81, i), i == 0, 1'b0);
    idle();
    chk("R9 pre state", 32'(cell_ready), 32'd1);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1);
    chk("R9 empty after clear", 32'(cell_ready), 32'd0);
    chk("R9 clav after clear", 32'(tx_clav), 32'd1);
    chk("R9 par_err cleared", 32'(par_err), 32'd0);
    chk("R11 level2 on", 32'(mode_l2), 32'd1);
    for (int i = 20; i < 30; i++) beat(wd(81, i), 1'b0, 1'b0);
    idle();
    chk("R9 truncated tail ignored", 32'(tx_clav), 32'd1);
    send_cell(82, -1);
    read_cell("R9 normal after clear", 82);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0);
    chk("R11 level2 off", 32'(mode_l2), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_byte_cell();
    t_word_cell();
    t_threshold();
    t_hold();
    t_full();
    t_parity();
    t_soc_mid();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule